// File: doc/BRIEF.md
# EPP Host-Side Cycle Controller

This block sits between a host I/O bus and an enhanced parallel port. It runs one byte-wide transfer at a time on the port bus. A transfer is a read or a write, aimed at either the address channel or the data channel. The host raises a level read request or a level write request and holds it for the whole transfer. A select bit picks address or data. For a write, a byte comes with the request.

The controller checks that the peripheral is ready, which it signals with wait low. It then sets up the write line and the bus direction and pulses exactly one strobe. It waits for the peripheral to raise wait. For a read, it captures the port byte on that cycle. The strobe stays asserted until the host drops its request. After the strobe, the write line, direction and data drive are held for one more cycle, so the peripheral can let go of the bus first.

The port bus is split into input, output and an output enable. A control-register direction bit and a write-line override input come from a legacy control path. The interrupt and device-reset lines pass straight through. The host side uses plain request levels rather than a valid/ready stream. Back-pressure is expressed as the host holding its request until the transfer completes.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: While reset is active and after it, no transfer is in progress. Both strobes and the write line are high, the output enable is 0, `host_busy` is 0 and `host_rdata` is 0. The direction output equals `ctl_dir`.
- R2: A transfer starts only from idle, and only when the wait input (through a two-flop synchronizer) is low. A host request made while wait is high leaves the strobes, `host_busy` and the output enable inactive.
- R3: A transfer asserts exactly one strobe: `port_addr_stb_n` when `host_addr_sel` is 1, otherwise `port_data_stb_n`. The two strobes are never low together.
- R4: The write line is low from the setup cycle of a write transfer through its release cycle. It stays high during reads and idle unless R10 applies.
- R5: The direction output is 1 whenever `ctl_dir` is 1 or a read transfer is in progress, and 0 otherwise.
- R6: The output enable is 1 only during a write transfer with the direction output at 0. While it is 1, `port_dout` carries the byte latched from `host_wdata` when the transfer started.
- R7: In a read transfer, `port_din` is captured into `host_rdata` on the cycle in which the synchronized wait is first seen high. The value stays there until the next read.
- R8: An asserted strobe is held until wait has been seen high and the host request for that transfer has been dropped. It is released on the next clock edge after both are true.
- R9: For one cycle after the strobe is released, the write line, the direction output and the output enable keep their transfer values. On the following cycle they return to idle values.
- R10: `spp_wr_force` high drives the write line low in any state.
- R11: `host_intr` follows `port_intr` without inversion. `port_reset_n` is the inverse of `host_dev_reset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Host read request, held for the transfer |
| host_wr | input | 1 | Host write request, held for the transfer |
| host_addr_sel | input | 1 | 1 selects the address channel, 0 the data channel |
| host_wdata | input | DATA_W | Byte to write |
| host_rdata | output | DATA_W | Last byte read |
| host_busy | output | 1 | A transfer is in progress |
| host_intr | output | 1 | Interrupt to the host |
| host_dev_reset | input | 1 | Host request to reset the peripheral |
| ctl_dir | input | 1 | Control-register direction bit |
| spp_wr_force | input | 1 | Legacy override that pulls the write line low |
| port_write_n | output | 1 | Active-low write line |
| port_data_stb_n | output | 1 | Active-low data strobe |
| port_addr_stb_n | output | 1 | Active-low address strobe |
| port_reset_n | output | 1 | Active-low peripheral reset |
| port_dir | output | 1 | Bus direction, 1 for input/read |
| port_wait_n | input | 1 | Peripheral wait handshake |
| port_intr | input | 1 | Peripheral interrupt |
| port_din | input | DATA_W | Port bus input |
| port_dout | output | DATA_W | Port bus output |
| port_oe | output | 1 | Port bus output enable |

## Verification
The four kinds of transfer are run with random bytes and random `ctl_dir` settings. These runs separate the address strobe from the data strobe, and reads from writes in the write line, the direction and the output enable. They also show that `ctl_dir` blocks the output drive without stopping the transfer. Each transfer keeps the host request up well after the acknowledge, to show that the strobe waits for the host. A sample just after the strobe and one a cycle later tell the release cycle apart from the return to idle. Directed cases hold wait high with a request pending, apply the write-line override while idle, and toggle the pass-through lines.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_STROBE  = 3'd2,
    ST_HOLD    = 3'd3,
    ST_RELEASE = 3'd4
  } epp_state_e;
endpackage

// File: rtl/epp_wait_sync.sv
module epp_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/epp_cycle_fsm.sv
module epp_cycle_fsm
  import epp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              host_addr_sel,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              wait_s,
  input  logic [DATA_W-1:0] port_din,
  output epp_state_e        state,
  output logic              is_read,
  output logic              is_addr,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  epp_state_e state_d;
  logic       req_live;

  // the host request belonging to the transfer in flight
  assign req_live = is_read ? host_rd : host_wr;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:    if ((host_rd || host_wr) && !wait_s) state_d = ST_SETUP;
      ST_SETUP:   state_d = ST_STROBE;
      ST_STROBE:  if (wait_s) state_d = ST_HOLD;
      ST_HOLD:    if (!req_live) state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      is_read <= 1'b0;
      is_addr <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state <= state_d;
      if (state == ST_IDLE && state_d == ST_SETUP) begin
        is_read <= host_rd;
        is_addr <= host_addr_sel;
        wdata_q <= host_wdata;
      end
      if (state == ST_STROBE && wait_s && is_read) rdata_q <= port_din;
    end
  end
endmodule

// File: rtl/epp_port_drive.sv
module epp_port_drive
  import epp_pkg::*;
(
  input  epp_state_e state,
  input  logic       is_read,
  input  logic       is_addr,
  input  logic       ctl_dir,
  input  logic       spp_wr_force,
  output logic       write_n,
  output logic       data_stb_n,
  output logic       addr_stb_n,
  output logic       dir,
  output logic       oe,
  output logic       busy
);
  logic active, strobing;

  assign active   = (state != ST_IDLE);
  assign strobing = (state == ST_STROBE) || (state == ST_HOLD);

  always_comb begin
    busy       = active;
    write_n    = !((active && !is_read) || spp_wr_force);
    data_stb_n = !(strobing && !is_addr);
    addr_stb_n = !(strobing && is_addr);
    dir        = ctl_dir || (active && is_read);
    oe         = active && !is_read && !dir;
  end
endmodule

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl
  import epp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              host_addr_sel,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_busy,
  output logic              host_intr,
  input  logic              host_dev_reset,
  input  logic              ctl_dir,
  input  logic              spp_wr_force,
  output logic              port_write_n,
  output logic              port_data_stb_n,
  output logic              port_addr_stb_n,
  output logic              port_reset_n,
  output logic              port_dir,
  input  logic              port_wait_n,
  input  logic              port_intr,
  input  logic [DATA_W-1:0] port_din,
  output logic [DATA_W-1:0] port_dout,
  output logic              port_oe
);
  epp_state_e        state;
  logic              wait_sync, is_read, is_addr;
  logic [DATA_W-1:0] wdata_q;

  epp_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(port_wait_n), .sync_out(wait_sync)
  );

  epp_cycle_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr_sel(host_addr_sel), .host_wdata(host_wdata),
    .wait_s(wait_sync), .port_din(port_din), .state(state),
    .is_read(is_read), .is_addr(is_addr), .wdata_q(wdata_q),
    .rdata_q(host_rdata)
  );

  epp_port_drive u_drv (
    .state(state), .is_read(is_read), .is_addr(is_addr),
    .ctl_dir(ctl_dir), .spp_wr_force(spp_wr_force),
    .write_n(port_write_n), .data_stb_n(port_data_stb_n),
    .addr_stb_n(port_addr_stb_n), .dir(port_dir), .oe(port_oe),
    .busy(host_busy)
  );

  assign port_dout    = wdata_q;
  assign host_intr    = port_intr;
  assign port_reset_n = !host_dev_reset;
endmodule

// File: rtl/epp_cycle_ctrl_chk.sv
module epp_cycle_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic host_rd,
  input logic host_wr,
  input logic host_busy,
  input logic wait_sync,
  input logic ctl_dir,
  input logic port_dir,
  input logic port_oe,
  input logic port_data_stb_n,
  input logic port_addr_stb_n
);
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!port_data_stb_n && !port_addr_stb_n));

  p_start_wait_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_busy) |-> !$past(wait_sync));

  p_ctl_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_dir |-> port_dir);

  p_oe_needs_out_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    port_oe |-> (!port_dir && host_busy));

  p_release_after_host_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(port_data_stb_n) || $rose(port_addr_stb_n)) |-> (!$past(host_rd) && !$past(host_wr)));

  p_hold_after_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(port_data_stb_n) || $rose(port_addr_stb_n)) |-> host_busy);
endmodule

bind epp_cycle_ctrl epp_cycle_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
  .host_busy(host_busy), .wait_sync(wait_sync), .ctl_dir(ctl_dir),
  .port_dir(port_dir), .port_oe(port_oe),
  .port_data_stb_n(port_data_stb_n), .port_addr_stb_n(port_addr_stb_n)
);

// File: tb/epp_cycle_ctrl_tb_top.sv
module epp_cycle_ctrl_tb_top;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_rd = 0, host_wr = 0, host_addr_sel = 0, host_dev_reset = 0;
  logic ctl_dir = 0, spp_wr_force = 0, port_wait_n = 0, port_intr = 0;
  logic [DW-1:0] host_wdata = '0, port_din = '0;
  logic [DW-1:0] host_rdata, port_dout;
  logic host_busy, host_intr, port_write_n, port_data_stb_n, port_addr_stb_n;
  logic port_reset_n, port_dir, port_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  epp_cycle_ctrl #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr_sel(host_addr_sel), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_busy(host_busy), .host_intr(host_intr),
    .host_dev_reset(host_dev_reset), .ctl_dir(ctl_dir),
    .spp_wr_force(spp_wr_force), .port_write_n(port_write_n),
    .port_data_stb_n(port_data_stb_n), .port_addr_stb_n(port_addr_stb_n),
    .port_reset_n(port_reset_n), .port_dir(port_dir),
    .port_wait_n(port_wait_n), .port_intr(port_intr), .port_din(port_din),
    .port_dout(port_dout), .port_oe(port_oe)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_dir(input bit rd, input bit cdir);
    return cdir | rd;
  endfunction
  function automatic bit exp_oe(input bit rd, input bit cdir);
    return !rd && !exp_dir(rd, cdir);
  endfunction

  task automatic run_xfer(input bit rd, input bit addr, input logic [DW-1:0] b,
                          input logic [DW-1:0] resp, input bit cdir);
    bit seen = 0;
    @(negedge clk);
    ctl_dir = cdir; host_addr_sel = addr; host_wdata = b;
    host_rd = rd; host_wr = !rd;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!port_data_stb_n || !port_addr_stb_n) begin seen = 1; break; end
    end
    chk("R3", "strobe seen", int'(seen), 1);
    chk("R3", "addr strobe", int'(port_addr_stb_n), int'(!addr));
    chk("R3", "data strobe", int'(port_data_stb_n), int'(addr));
    chk("R4", "write line", int'(port_write_n), int'(rd));
    chk("R5", "dir in xfer", int'(port_dir), int'(exp_dir(rd, cdir)));
    chk("R6", "oe in xfer", int'(port_oe), int'(exp_oe(rd, cdir)));
    if (!rd) chk("R6", "dout", int'(port_dout), int'(b));
    port_din = resp; port_wait_n = 1;
    repeat (8) @(negedge clk);
    chk("R8", "strobe held for host", int'(port_data_stb_n & port_addr_stb_n), 0);
    if (rd) chk("R7", "rdata", int'(host_rdata), int'(resp));
    host_rd = 0; host_wr = 0;
    @(negedge clk);
    chk("R8", "strobe released", int'(port_data_stb_n & port_addr_stb_n), 1);
    chk("R9", "write held", int'(port_write_n), int'(rd));
    chk("R9", "dir held", int'(port_dir), int'(exp_dir(rd, cdir)));
    chk("R9", "oe held", int'(port_oe), int'(exp_oe(rd, cdir)));
    @(negedge clk);
    chk("R9", "write idle", int'(port_write_n), 1);
    chk("R9", "dir idle", int'(port_dir), int'(cdir));
    chk("R9", "oe idle", int'(port_oe), 0);
    port_wait_n = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", int'(host_busy), 0);
    chk("R1", "strobes", int'(port_data_stb_n & port_addr_stb_n), 1);
    chk("R1", "write", int'(port_write_n), 1);
    chk("R1", "oe", int'(port_oe), 0);
    chk("R1", "dir", int'(port_dir), 0);
    chk("R1", "rdata", int'(host_rdata), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // directed: each kind of transfer
    run_xfer(0, 0, 8'hA5, 8'h00, 0);
    run_xfer(0, 1, 8'h3C, 8'h00, 0);
    run_xfer(1, 0, 8'h00, 8'h5A, 0);
    run_xfer(1, 1, 8'h00, 8'hC3, 0);
    run_xfer(0, 0, 8'h77, 8'h00, 1);

    // R2 wait high blocks start
    port_wait_n = 1; repeat (3) @(negedge clk);
    host_wr = 1; host_wdata = 8'h11;
    repeat (10) @(negedge clk);
    chk("R2", "busy blocked", int'(host_busy), 0);
    chk("R2", "strobes blocked", int'(port_data_stb_n & port_addr_stb_n), 1);
    chk("R2", "oe blocked", int'(port_oe), 0);
    host_wr = 0; @(negedge clk);
    port_wait_n = 0; repeat (3) @(negedge clk);

    // R10 override
    spp_wr_force = 1; @(negedge clk);
    chk("R10", "forced write", int'(port_write_n), 0);
    spp_wr_force = 0; @(negedge clk);
    chk("R10", "release force", int'(port_write_n), 1);

    // R11 pass-through
    port_intr = 1; host_dev_reset = 1; #1;
    chk("R11", "intr", int'(host_intr), 1);
    chk("R11", "dev reset", int'(port_reset_n), 0);
    port_intr = 0; host_dev_reset = 0; #1;
    chk("R11", "intr low", int'(host_intr), 0);
    chk("R11", "dev reset off", int'(port_reset_n), 1);

    // random transfers
    for (int n = 0; n < 40; n++) begin
      logic [31:0] r;
      r = $urandom;
      run_xfer(r[0], r[1], r[15:8], r[23:16], (r[5:2] == 4'd0));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule